// File: doc/BRIEF.md
# Sector Protection and Identification Unit

This unit sits beside the command logic of a two-bank flash array. For every incoming word address it works out which sector is addressed and reports whether a program or erase may proceed there. The address space is not uniform. With the default top-boot layout, 31 large sectors are chosen by the five most significant address bits. When those bits are all ones, the next three bits choose one of eight small boot sectors, which gives 39 sectors in total. A parameter selects the mirrored bottom-boot layout instead, with the boot sectors at address zero.

Each sector has one stored protect bit. A protect strobe sets the bit of the currently addressed sector and an unprotect strobe clears it. The write-protect pin arrives already decoded as a 2-bit level:

- At the low level, the two outermost boot sectors are always locked.
- At the normal high level, every sector follows its stored bit.
- At the elevated level, all sectors are writable for as long as that level is held.

When identification mode is active, the unit returns an 8-bit code instead: manufacturer, device, protection of the addressed sector, or the secure-sector lock indicator.

Top module: `boot_protect_unit`

## Requirements
- R1: With the default top-boot map, addr[19:15] = k with k < 31 selects large sector k. When addr[19:15] = 31, addr[14:12] = j selects boot sector 31 + j. The two outermost sectors are 37 and 38 (addr[19:12] = FEh and FFh).
- R2: When pin_lvl = 2'b00 (low), write_ok is 0 in sectors 37 and 38 whatever their stored bits are. Every other sector gives write_ok = NOT its stored bit.
- R3: When pin_lvl = 2'b01 (high), write_ok is NOT the stored bit of the addressed sector, for every sector including 37 and 38.
- R4: When pin_lvl = 2'b10 (elevated), write_ok is 1 for every sector, and the stored bits are left unchanged once that level is removed.
- R5: A protect strobe sets the stored bit of the addressed sector, taking effect from the next clock edge. An unprotect strobe clears it in the same way. If both strobes are active together, the protect strobe wins.
- R6: Reset clears every stored bit. A clock edge without a strobe changes no stored bit.
- R7: When id_mode = 1 and addr[6] = 0, addr[1:0] selects the value of id_data: 00 gives 01h, 01 gives 95h, 10 gives 01h if write_ok is 0 and 00h if it is 1, and 11 gives 85h (factory locked, the default).
- R8: id_data is 00h when id_mode = 0, and also when id_mode = 1 with addr[6] = 1.
- R9: pin_lvl = 2'b11 is treated exactly like the high level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | Word address |
| pin_lvl | input | 2 | Decoded write-protect pin level (00 low, 01 high, 10 elevated, 11 as high) |
| prot_stb | input | 1 | Set the protect bit of the addressed sector |
| unprot_stb | input | 1 | Clear the protect bit of the addressed sector |
| id_mode | input | 1 | Identification read mode |
| write_ok | output | 1 | Program or erase is allowed at the addressed sector |
| id_data | output | 8 | Identification value |

## Verification
The assertions assume that the address and strobes are stable around each rising clock edge and free of X after reset. They also assume that the decoded pin level is one of the four 2-bit codes. The stimulus meets these assumptions by changing every input only on the falling edge and by drawing the pin level from the full 2-bit range. The stimulus also combines both strobes, and issues strobes while the pin is at the elevated level, because stored bits must still change at that level even though they have no effect on write_ok.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [1:0] {
        PIN_LOW  = 2'b00,
        PIN_HIGH = 2'b01,
        PIN_ELEV = 2'b10,
        PIN_RSVD = 2'b11
    } pin_lvl_e;

    localparam logic [7:0] MFR_CODE    = 8'h01;
    localparam logic [7:0] DEV_TOP     = 8'h95;
    localparam logic [7:0] DEV_BOT     = 8'h96;
    localparam logic [7:0] LOCK_FACT   = 8'h85;
    localparam logic [7:0] LOCK_CUST   = 8'h05;

    typedef enum logic [1:0] {
        ID_MFR  = 2'b00,
        ID_DEV  = 2'b01,
        ID_PROT = 2'b10,
        ID_LOCK = 2'b11
    } id_sel_e;

    function automatic logic [7:0] id_code(input logic top, input logic locked,
                                           input id_sel_e sel, input logic prot);
        case (sel)
            ID_MFR:  id_code = MFR_CODE;
            ID_DEV:  id_code = top ? DEV_TOP : DEV_BOT;
            ID_PROT: id_code = {7'b0, prot};
            default: id_code = locked ? LOCK_FACT : LOCK_CUST;
        endcase
    endfunction

endpackage

// File: rtl/sector_decode.sv
module sector_decode #(
    parameter int ADDR_W   = 20,
    parameter int BIG_W    = 5,
    parameter int BOOT_W   = 3,
    parameter bit TOP_BOOT = 1'b1,
    localparam int NUM_BIG  = (1 << BIG_W) - 1,
    localparam int NUM_BOOT = 1 << BOOT_W,
    localparam int NUM_SECT = NUM_BIG + NUM_BOOT,
    localparam int SECT_W   = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] idx,
    output logic              outer
);
    logic [BIG_W-1:0]  big;
    logic [BOOT_W-1:0] boot;
    logic              in_boot;

    assign big  = addr[ADDR_W-1 -: BIG_W];
    assign boot = addr[ADDR_W-BIG_W-1 -: BOOT_W];

    generate
        if (TOP_BOOT) begin : g_top
            assign in_boot = &big;
            assign idx   = in_boot ? SECT_W'(NUM_BIG) + SECT_W'(boot) : SECT_W'(big);
            assign outer = in_boot && (boot >= BOOT_W'(NUM_BOOT - 2));
        end else begin : g_bot
            assign in_boot = ~|big;
            assign idx   = in_boot ? SECT_W'(boot)
                                   : SECT_W'(NUM_BOOT) + SECT_W'(big) - SECT_W'(1);
            assign outer = in_boot && (boot < BOOT_W'(2));
        end
    endgenerate

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx < SECT_W'(NUM_SECT));

    // R1
    outer_boot_chk: assert property (@(posedge clk) disable iff (rst)
        outer |-> (idx < SECT_W'(2) || idx >= SECT_W'(NUM_SECT - 2)));

endmodule

// File: rtl/protect_regs.sv
module protect_regs #(
    parameter int NUM_SECT = 39,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SECT_W-1:0]   idx,
    input  logic                set_stb,
    input  logic                clr_stb,
    output logic [NUM_SECT-1:0] bits
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= '0;
        end else if (set_stb) begin
            bits[idx] <= 1'b1;
        end else if (clr_stb) begin
            bits[idx] <= 1'b0;
        end
    end

    // R5
    set_bit_chk: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> bits[$past(idx)]);

    // R5
    clr_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && !set_stb) |=> !bits[$past(idx)]);

    // R6
    hold_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(bits));

    // R5
    one_change_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(bits ^ $past(bits)) <= 1));

endmodule

// File: rtl/id_mux.sv
module id_mux
    import bpu_pkg::*;
#(
    parameter bit TOP_BOOT       = 1'b1,
    parameter bit FACTORY_LOCKED = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       id_mode,
    input  logic       sel_hi,
    input  logic [1:0] sel,
    input  logic       prot_now,
    output logic [7:0] id_data
);
    always_comb begin
        if (id_mode && !sel_hi)
            id_data = id_code(TOP_BOOT, FACTORY_LOCKED, id_sel_e'(sel), prot_now);
        else
            id_data = 8'h00;
    end

    // R8
    id_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!id_mode || sel_hi) |-> (id_data == 8'h00));

    // R7
    id_prot_chk: assert property (@(posedge clk) disable iff (rst)
        (id_mode && !sel_hi && sel == 2'b10) |-> (id_data == {7'b0, prot_now}));

endmodule

// File: rtl/boot_protect_unit.sv
module boot_protect_unit
    import bpu_pkg::*;
#(
    parameter int ADDR_W         = 20,
    parameter int BIG_W          = 5,
    parameter int BOOT_W         = 3,
    parameter bit TOP_BOOT       = 1'b1,
    parameter bit FACTORY_LOCKED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        pin_lvl,
    input  logic              prot_stb,
    input  logic              unprot_stb,
    input  logic              id_mode,
    output logic              write_ok,
    output logic [7:0]        id_data
);
    localparam int NUM_SECT = (1 << BIG_W) - 1 + (1 << BOOT_W);
    localparam int SECT_W   = $clog2(NUM_SECT);

    logic [SECT_W-1:0]   idx;
    logic                outer;
    logic [NUM_SECT-1:0] bits;
    logic                eff_prot;
    pin_lvl_e            lvl;

    assign lvl = pin_lvl_e'(pin_lvl);

    sector_decode #(
        .ADDR_W(ADDR_W), .BIG_W(BIG_W), .BOOT_W(BOOT_W), .TOP_BOOT(TOP_BOOT)
    ) u_dec (
        .clk(clk), .rst(rst), .addr(addr), .idx(idx), .outer(outer)
    );

    protect_regs #(.NUM_SECT(NUM_SECT)) u_regs (
        .clk(clk), .rst(rst), .idx(idx),
        .set_stb(prot_stb), .clr_stb(unprot_stb), .bits(bits)
    );

    always_comb begin
        case (lvl)
            PIN_ELEV: eff_prot = 1'b0;
            PIN_LOW:  eff_prot = bits[idx] | outer;
            default:  eff_prot = bits[idx];
        endcase
    end

    assign write_ok = ~eff_prot;

    id_mux #(.TOP_BOOT(TOP_BOOT), .FACTORY_LOCKED(FACTORY_LOCKED)) u_id (
        .clk(clk), .rst(rst), .id_mode(id_mode), .sel_hi(addr[6]),
        .sel(addr[1:0]), .prot_now(eff_prot), .id_data(id_data)
    );

    // R4
    elev_open_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_lvl == 2'b10) |-> write_ok);

    // R2
    low_outer_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_lvl == 2'b00 && outer) |-> !write_ok);

    // R3
    high_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_lvl[0] && !outer) |-> (write_ok == !bits[idx]));

endmodule

// File: tb/boot_protect_unit_test.sv
`timescale 1ns/1ps
module boot_protect_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] addr;
    logic [1:0]  pin_lvl;
    logic        prot_stb, unprot_stb, id_mode;
    logic        write_ok;
    logic [7:0]  id_data;

    int checks = 0;
    int errors = 0;
    bit [38:0] mdl;

    always #4 clk = ~clk;

    boot_protect_unit uut (
        .clk(clk), .rst(rst), .addr(addr), .pin_lvl(pin_lvl),
        .prot_stb(prot_stb), .unprot_stb(unprot_stb), .id_mode(id_mode),
        .write_ok(write_ok), .id_data(id_data)
    );

    function automatic int sect_of(input logic [19:0] a);
        if (a[19:15] != 5'h1F) return int'(a[19:15]);
        return 31 + int'(a[14:12]);
    endfunction

    function automatic bit exp_ok(input logic [19:0] a, input logic [1:0] p);
        int s = sect_of(a);
        if (p == 2'b10) return 1'b1;
        if (p == 2'b00 && s >= 37) return 1'b0;
        return !mdl[s];
    endfunction

    function automatic logic [7:0] exp_id(input logic [19:0] a, input logic [1:0] p,
                                          input logic m);
        if (!m || a[6]) return 8'h00;
        case (a[1:0])
            2'b00: return 8'h01;
            2'b01: return 8'h95;
            2'b10: return exp_ok(a, p) ? 8'h00 : 8'h01;
            default: return 8'h85;
        endcase
    endfunction

    task automatic chk_ok(input string req);
        bit e = exp_ok(addr, pin_lvl);
        checks++;
        if (write_ok !== e) begin
            errors++;
            $display("FAIL %s write_ok addr=%h pin=%b actual=%b expected=%b",
                     req, addr, pin_lvl, write_ok, e);
        end
    endtask

    task automatic chk_id(input string req);
        logic [7:0] e = exp_id(addr, pin_lvl, id_mode);
        checks++;
        if (id_data !== e) begin
            errors++;
            $display("FAIL %s id_data addr=%h mode=%b actual=%h expected=%h",
                     req, addr, id_mode, id_data, e);
        end
    endtask

    // drive at negedge, then clock one edge and update the model
    task automatic strobe(input logic [19:0] a, input logic ps, input logic us,
                          input logic [1:0] p);
        @(negedge clk);
        addr = a; prot_stb = ps; unprot_stb = us; pin_lvl = p;
        @(posedge clk);
        if (ps) mdl[sect_of(a)] = 1'b1;
        else if (us) mdl[sect_of(a)] = 1'b0;
        @(negedge clk);
        prot_stb = 1'b0; unprot_stb = 1'b0;
    endtask

    task automatic look(input logic [19:0] a, input logic [1:0] p, input string req);
        @(negedge clk);
        addr = a; pin_lvl = p;
        #1;
        chk_ok(req);
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 39; s++) begin
            logic [19:0] lo, hi;
            if (s < 31) begin
                lo = 20'(s) << 15; hi = lo | 20'h7FFF;
            end else begin
                lo = (20'h1F << 15) | (20'(s - 31) << 12); hi = lo | 20'hFFF;
            end
            for (int p = 0; p < 4; p++) begin
                look(lo, 2'(p), req);
                look(hi, 2'(p), req);
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC7_0A11));
        mdl = '0;
        rst = 1'b1; addr = '0; pin_lvl = 2'b01;
        prot_stb = 0; unprot_stb = 0; id_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R6: reset state, all unprotected at high level
        look(20'h00000, 2'b01, "R6");
        look(20'hFF123, 2'b01, "R6");
        // R2: low level locks outermost even when unprotected
        look(20'hFE000, 2'b00, "R2");
        look(20'hFFFFF, 2'b00, "R2");
        look(20'hFDFFF, 2'b00, "R2");

        // R5: protect some sectors, clear one, both strobes together
        strobe(20'hFF000, 1, 0, 2'b01);
        strobe(20'h00010, 1, 0, 2'b01);
        strobe(20'h48000, 1, 0, 2'b01);
        strobe(20'hFA000, 1, 1, 2'b01);
        strobe(20'h48000, 0, 1, 2'b01);
        // R4: strobes applied while elevated still take effect
        strobe(20'h80000, 1, 0, 2'b10);
        look(20'h80000, 2'b10, "R4");
        look(20'h80000, 2'b01, "R4");
        look(20'hFF000, 2'b01, "R3");
        look(20'hFA800, 2'b11, "R9");
        look(20'h48000, 2'b01, "R5");
        look(20'h0FFFF, 2'b00, "R2");
        // R6: no strobe leaves bits untouched
        @(negedge clk); @(negedge clk);
        look(20'h00000, 2'b01, "R6");

        // R1: full boundary sweep for every pin level
        sweep("R1");

        // R7/R8 identification codes
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            id_mode = 1'b1;
            addr = 20'hFF000 | 20'(k[1:0]) | (k[2] ? 20'h40 : 20'h0);
            pin_lvl = 2'b01;
            #1; chk_id(k[2] ? "R8" : "R7");
        end
        @(negedge clk); addr = 20'h00002; pin_lvl = 2'b01; #1; chk_id("R7");
        @(negedge clk); addr = 20'hFE002; pin_lvl = 2'b00; #1; chk_id("R7");
        @(negedge clk); addr = 20'h00001; id_mode = 1'b0; #1; chk_id("R8");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [19:0] a = 20'($urandom);
            logic [1:0]  p = 2'($urandom);
            int op = $urandom % 5;
            @(negedge clk);
            addr = a; pin_lvl = p; id_mode = 1'($urandom);
            prot_stb = (op == 1 || op == 3);
            unprot_stb = (op == 2 || op == 3);
            #1;
            chk_ok("R3");
            chk_id("R7");
            @(posedge clk);
            if (prot_stb) mdl[sect_of(a)] = 1'b1;
            else if (unprot_stb) mdl[sect_of(a)] = 1'b0;
        end
        @(negedge clk); prot_stb = 0; unprot_stb = 0; id_mode = 0;
        sweep("R2");

        // R6: reset clears everything
        @(negedge clk); rst = 1'b1;
        @(posedge clk); mdl = '0;
        @(negedge clk); rst = 1'b0;
        sweep("R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule